// File: doc/BRIEF.md
# Fractional MAC Result Rounder

This block is the output stage of a fractional multiply-accumulate datapath. Each accepted beat carries a wide signed accumulator value, two unsigned multiplier operands and three mode bits. From the accumulator it forms a register-sized word. In narrow mode that word is a 16-bit value taken from above bit 24 and always rounded to nearest-even. In wide mode it is a 32-bit value taken from above bit 8, rounded to nearest-even or truncated as the round bit selects. Either result can be clipped to its signed limits instead of wrapping.

In the same beat the block forms the scaled fractional product of the operands. This is the full unsigned product divided by 2^24. The round bit chooses between flooring this value and rounding it to nearest-even.

Data moves through one register stage with a valid/ready handshake. A beat is taken on a rising clock edge where `in_valid` and `in_ready` are both high, and its results appear one cycle later. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the output register and all of its fields hold, and no new beat is taken. The upstream side may present a beat and wait; it must keep the payload steady until the beat is taken.

Top module: `frac_mac_rounder`

## Requirements
- R1: An accepted beat (in_valid and in_ready high at a rising edge) drives out_valid high after that edge with its results. in_ready equals (not out_valid) or out_ready. With no beat taken while the output drains, out_valid falls after that edge.
- R2: While out_valid is high and out_ready is low, out_word and out_prod stay unchanged and in_ready is low.
- R3: While rst_n is low, out_valid is low and in_ready is high.
- R4: With in_half=1, in_acc is read as a 48-bit two's-complement value A. K = floor(A / 2^24) and the remainder is A mod 2^24. K is incremented if the remainder exceeds 0x800000. If the remainder equals 0x800000, K is incremented only when K is odd. The result goes to out_word[15:0], and out_word[31:16] is zero.
- R5: With in_half=0 and in_round=1, K = floor(A / 2^8), rounded to nearest-even on the 8 dropped bits with 0x80 as the halfway value. The result is out_word[31:0].
- R6: With in_half=0 and in_round=0, out_word is floor(A / 2^8) with no rounding.
- R7: With in_sat=1, a rounded K outside the signed range of the result width is clipped. In narrow mode it becomes 0x7FFF if K is positive and 0x8000 if K is negative. In wide mode it becomes 0x7FFFFFFF or 0x80000000 in the same way.
- R8: With in_sat=0, the result is the low 16 or 32 bits of K in two's complement.
- R9: With in_round=0, out_prod is floor(P / 2^24). P is the unsigned 64-bit product in_opa * in_opb.
- R10: With in_round=1, out_prod is P / 2^24 rounded to nearest-even on the 24 dropped bits, with 0x800000 as the halfway value.
- R11: In narrow mode the accumulator result is rounded regardless of in_round. in_round still controls out_prod.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Upstream beat present |
| in_ready | output | 1 | Stage can take a beat |
| in_acc | input | 48 | Signed fractional accumulator value |
| in_opa | input | 32 | Unsigned multiplier operand A |
| in_opb | input | 32 | Unsigned multiplier operand B |
| in_half | input | 1 | Select 16-bit accumulator result |
| in_round | input | 1 | Round-to-nearest-even enable (wide word and product) |
| in_sat | input | 1 | Clip out-of-range accumulator result |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Downstream takes the result |
| out_word | output | 32 | Rounded/clipped accumulator result |
| out_prod | output | 40 | Scaled fractional product |

## Verification
The state in this block is the output register and its valid flag. A wrong captured mode bit or a missed handshake shows up on the very next result beat: out_word then carries the wrong width, the wrong rounding or the wrong clip value. A hold failure during back-pressure shows as out_word or out_prod changing within one stalled cycle. Rounding faults only appear at exact halfway remainders with an even or odd kept value, so the sweeps pair every halfway and near-halfway remainder with both kept parities, both signs and the range limits. This exposes each fault on the beat that carries such an input.

// File: rtl/frac_mac_pkg.sv
`timescale 1ns/1ps
package frac_mac_pkg;

  // Per-beat control carried alongside the data.
  typedef struct packed {
    logic half;   // 16-bit accumulator result
    logic rnd;    // nearest-even rounding for wide word and product
    logic sat;    // clip instead of wrap
  } frac_mode_t;

  localparam int unsigned NARROW_SHIFT = 24;
  localparam int unsigned WIDE_SHIFT   = 8;
  localparam int unsigned PROD_SHIFT   = 24;

endpackage

// File: rtl/frac_rne_shift.sv
`timescale 1ns/1ps
// Right shift by SH with optional round-half-to-even on the dropped bits.
// Output is one bit wider than the kept field so the increment never wraps.
module frac_rne_shift #(
  parameter int unsigned IN_W   = 48,
  parameter int unsigned SH     = 24,
  parameter bit          SIGNED = 1'b1
) (
  input  logic [IN_W-1:0]    din,
  input  logic               round_en,
  output logic [IN_W-SH:0]   dout
);
  localparam int unsigned KW = IN_W - SH + 1;
  localparam logic [SH-1:0] HALFWAY = {1'b1, {(SH-1){1'b0}}};

  logic          ext_bit;
  logic [KW-1:0] kept;
  logic [SH-1:0] rem;
  logic          bump;

  generate
    if (SIGNED) begin : g_signed
      assign ext_bit = din[IN_W-1];
    end else begin : g_unsigned
      assign ext_bit = 1'b0;
    end
  endgenerate

  assign kept = {ext_bit, din[IN_W-1:SH]};
  assign rem  = din[SH-1:0];

  always_comb begin
    bump = 1'b0;
    if (round_en) begin
      if (rem > HALFWAY)
        bump = 1'b1;
      else if (rem == HALFWAY)
        bump = kept[0];
    end
  end

  assign dout = kept + {{(KW-1){1'b0}}, bump};
endmodule

// File: rtl/frac_sat_clip.sv
`timescale 1ns/1ps
// Narrow a signed value to OUT_W bits, clipping to the signed limits when enabled.
module frac_sat_clip #(
  parameter int unsigned IN_W  = 25,
  parameter int unsigned OUT_W = 16
) (
  input  logic [IN_W-1:0]  din,
  input  logic             sat_en,
  output logic [OUT_W-1:0] dout
);
  localparam int unsigned TOP_W = IN_W - OUT_W + 1;

  logic [TOP_W-1:0] top_bits;
  logic             in_range;
  logic             neg;

  assign top_bits = din[IN_W-1:OUT_W-1];
  assign in_range = (&top_bits) | ~(|top_bits);
  assign neg      = din[IN_W-1];

  always_comb begin
    if (sat_en && !in_range)
      dout = {neg, {(OUT_W-1){~neg}}};
    else
      dout = din[OUT_W-1:0];
  end
endmodule

// File: rtl/frac_mac_rounder.sv
`timescale 1ns/1ps
module frac_mac_rounder #(
  parameter int unsigned ACC_W    = 48,
  parameter int unsigned OP_W     = 32,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned PROD_W   = 2 * OP_W - frac_mac_pkg::PROD_SHIFT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [ACC_W-1:0]    in_acc,
  input  logic [OP_W-1:0]     in_opa,
  input  logic [OP_W-1:0]     in_opb,
  input  logic                in_half,
  input  logic                in_round,
  input  logic                in_sat,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [WORD_W-1:0]   out_word,
  output logic [PROD_W-1:0]   out_prod
);
  import frac_mac_pkg::*;

  localparam int unsigned NRW_RW  = ACC_W - NARROW_SHIFT + 1;
  localparam int unsigned WIDE_RW = ACC_W - WIDE_SHIFT + 1;
  localparam int unsigned PRAW_W  = 2 * OP_W;
  localparam int unsigned PRND_W  = PRAW_W - PROD_SHIFT + 1;

  frac_mode_t mode;
  assign mode = '{half: in_half, rnd: in_round, sat: in_sat};

  // Narrow path: always rounds.
  logic [NRW_RW-1:0]   nrw_rounded;
  logic [NARROW_W-1:0] nrw_clipped;

  frac_rne_shift #(.IN_W(ACC_W), .SH(NARROW_SHIFT), .SIGNED(1'b1)) u_nrw_rnd (
    .din(in_acc), .round_en(1'b1), .dout(nrw_rounded));

  frac_sat_clip #(.IN_W(NRW_RW), .OUT_W(NARROW_W)) u_nrw_clip (
    .din(nrw_rounded), .sat_en(mode.sat), .dout(nrw_clipped));

  // Wide path: rounding selectable.
  logic [WIDE_RW-1:0] wide_rounded;
  logic [WORD_W-1:0]  wide_clipped;

  frac_rne_shift #(.IN_W(ACC_W), .SH(WIDE_SHIFT), .SIGNED(1'b1)) u_wide_rnd (
    .din(in_acc), .round_en(mode.rnd), .dout(wide_rounded));

  frac_sat_clip #(.IN_W(WIDE_RW), .OUT_W(WORD_W)) u_wide_clip (
    .din(wide_rounded), .sat_en(mode.sat), .dout(wide_clipped));

  // Fractional product path.
  logic [PRAW_W-1:0] prod_raw;
  logic [PRND_W-1:0] prod_rounded;

  assign prod_raw = {{OP_W{1'b0}}, in_opa} * {{OP_W{1'b0}}, in_opb};

  frac_rne_shift #(.IN_W(PRAW_W), .SH(PROD_SHIFT), .SIGNED(1'b0)) u_prod_rnd (
    .din(prod_raw), .round_en(mode.rnd), .dout(prod_rounded));

  logic [WORD_W-1:0] word_next;
  assign word_next = mode.half ? {{(WORD_W-NARROW_W){1'b0}}, nrw_clipped} : wide_clipped;

  // Output register with valid/ready handshake.
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_word <= '0;
      out_prod <= '0;
    end else if (take) begin
      out_word <= word_next;
      out_prod <= prod_rounded[PROD_W-1:0];
    end
  end
endmodule

// File: rtl/frac_mac_rounder_chk.sv
`timescale 1ns/1ps
module frac_mac_rounder_chk #(
  parameter int unsigned ACC_W    = 48,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned PROD_W   = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ACC_W-1:0]  in_acc,
  input logic              in_half,
  input logic              in_sat,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word,
  input logic [PROD_W-1:0] out_prod
);
  logic half_q, sat_q, sgn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      sat_q  <= 1'b0;
      sgn_q  <= 1'b0;
    end else if (in_valid && in_ready) begin
      half_q <= in_half;
      sat_q  <= in_sat;
      sgn_q  <= in_acc[ACC_W-1];
    end
  end

  // R1
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R1
  free_is_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_prod));

  // R4
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && half_q |-> out_word[WORD_W-1:NARROW_W] == '0);

  // R7
  narrow_pos_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && half_q && sat_q && !sgn_q |-> !out_word[NARROW_W-1]);

  // R7
  wide_pos_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !half_q && sat_q && !sgn_q |-> !out_word[WORD_W-1]);
endmodule

bind frac_mac_rounder frac_mac_rounder_chk #(
  .ACC_W(ACC_W), .WORD_W(WORD_W), .NARROW_W(NARROW_W), .PROD_W(PROD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_acc(in_acc), .in_half(in_half), .in_sat(in_sat),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_word(out_word), .out_prod(out_prod)
);

// File: tb/frac_mac_rounder_test.sv
`timescale 1ns/1ps
module frac_mac_rounder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [47:0] in_acc = '0;
  logic [31:0] in_opa = '0;
  logic [31:0] in_opb = '0;
  logic        in_half = 1'b0;
  logic        in_round = 1'b0;
  logic        in_sat = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;
  logic [39:0] out_prod;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  frac_mac_rounder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_acc(in_acc), .in_opa(in_opa), .in_opb(in_opb),
    .in_half(in_half), .in_round(in_round), .in_sat(in_sat),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_prod(out_prod));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_word(logic [47:0] acc, bit h, bit r, bit s);
    longint v, k, rm;
    v = longint'({{16{acc[47]}}, acc});
    if (h) begin
      k  = v >>> 24;
      rm = v & 64'hFF_FFFF;
      if (rm > 64'h80_0000) k = k + 1;
      else if (rm == 64'h80_0000) k = k + (k & 1);
      if (s && (k > 32767 || k < -32768)) return (k < 0) ? 32'h0000_8000 : 32'h0000_7FFF;
      return {16'h0000, k[15:0]};
    end
    k  = v >>> 8;
    rm = v & 64'hFF;
    if (r) begin
      if (rm > 64'h80) k = k + 1;
      else if (rm == 64'h80) k = k + (k & 1);
    end
    if (s && (k > 64'sh7FFF_FFFF || k < -64'sh8000_0000))
      return (k < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
    return k[31:0];
  endfunction

  function automatic logic [39:0] ref_prod(logic [31:0] a, logic [31:0] b, bit r);
    logic [63:0] p, q;
    logic [23:0] rm;
    p  = {32'h0, a} * {32'h0, b};
    q  = p >> 24;
    rm = p[23:0];
    if (r) begin
      if (rm > 24'h80_0000) q = q + 1;
      else if (rm == 24'h80_0000) q = q + {63'h0, q[0]};
    end
    return q[39:0];
  endfunction

  function automatic bit word_out_of_range(logic [47:0] acc, bit h, bit r);
    logic [31:0] wrap, clip;
    wrap = ref_word(acc, h, r, 1'b0);
    clip = ref_word(acc, h, r, 1'b1);
    return wrap != clip;
  endfunction

  // Present one beat at a falling edge; it is taken at the next rising edge
  // and checked at the falling edge after that.
  task automatic beat(input logic [47:0] acc, input logic [31:0] a, input logic [31:0] b,
                      input bit h, input bit r, input bit s, input string wtag, input string ptag);
    in_valid = 1'b1; out_ready = 1'b1;
    in_acc = acc; in_opa = a; in_opb = b;
    in_half = h; in_round = r; in_sat = s;
    @(negedge clk);
    check("R1 out_valid", {63'h0, out_valid}, 64'h1);
    check(wtag, {32'h0, out_word}, {32'h0, ref_word(acc, h, r, s)});
    if (ptag != "") check(ptag, {24'h0, out_prod}, {24'h0, ref_prod(a, b, r)});
  endtask

  function automatic logic [47:0] mk_acc(longint kept, longint rem, int sh);
    longint v;
    v = (kept <<< sh) | rem;
    return v[47:0];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    longint nk[14] = '{0, 1, 2, 3, -1, -2, 32766, 32767, 32768, -32768, -32769,
                       74565, 8388607, -8388608};
    longint nr[6]  = '{0, 1, 64'h7F_FFFF, 64'h80_0000, 64'h80_0001, 64'hFF_FFFF};
    longint wk[12] = '{0, 1, 2, -1, -2, 64'sh7FFF_FFFF, 64'sh7FFF_FFFE, -64'sh8000_0000,
                       -64'sh8000_0001, 64'sh8000_0000, 64'sh1_2345_6789, -64'sh7FFF_FFFF};
    longint wr[6]  = '{0, 1, 64'h7F, 64'h80, 64'h81, 64'hFF};
    logic [31:0] pb[6] = '{32'h0080_0000, 32'h0040_0000, 32'h00C0_0000,
                           32'h0080_0001, 32'h007F_FFFF, 32'hFFFF_FFFF};
    logic [47:0] acc_a, acc_b;
    string tag;

    // R3: reset state
    repeat (3) @(negedge clk);
    check("R3 out_valid in reset", {63'h0, out_valid}, 64'h0);
    check("R3 in_ready in reset", {63'h0, in_ready}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle out_valid", {63'h0, out_valid}, 64'h0);

    // Narrow sweep: R4, R7, R8, R11
    foreach (nk[i]) foreach (nr[j])
      for (int m = 0; m < 4; m++) begin
        acc_a = mk_acc(nk[i], nr[j], 24);
        if (word_out_of_range(acc_a, 1'b1, m[0])) tag = m[1] ? "R7 narrow clip" : "R8 narrow wrap";
        else tag = m[0] ? "R4 narrow round" : "R11 narrow rounds with round=0";
        beat(acc_a, 32'h0, 32'h0, 1'b1, m[0], m[1], tag, "");
      end

    // Wide sweep: R5, R6, R7, R8
    foreach (wk[i]) foreach (wr[j])
      for (int m = 0; m < 4; m++) begin
        acc_a = mk_acc(wk[i], wr[j], 8);
        if (word_out_of_range(acc_a, 1'b0, m[0])) tag = m[1] ? "R7 wide clip" : "R8 wide wrap";
        else tag = m[0] ? "R5 wide round" : "R6 wide truncate";
        beat(acc_a, 32'h0, 32'h0, 1'b0, m[0], m[1], tag, "");
      end

    // Product sweep: R9, R10, with R11 (narrow mode leaves product rounding to in_round)
    for (int i = 0; i < 64; i++) foreach (pb[j])
      for (int m = 0; m < 4; m++) begin
        beat(mk_acc(i, 64'h80_0000, 24), (m[1] ? 32'hFFFF_FFFF - i : i), pb[j],
             m[1], m[0], 1'b0, m[1] ? "R11 narrow word" : "R6 wide word",
             m[0] ? "R10 product rounded" : "R9 product floored");
      end

    // Back-pressure: R1, R2
    acc_a = mk_acc(5, 64'h80, 8);
    acc_b = mk_acc(-7, 64'h81, 8);
    beat(acc_a, 32'h0100_0000, 32'h0000_0003, 1'b0, 1'b1, 1'b0, "R5 stall beat A", "R10 stall beat A");
    out_ready = 1'b0;
    in_acc = acc_b; in_opa = 32'h0200_0000; in_opb = 32'h0000_0009;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R2 hold valid", {63'h0, out_valid}, 64'h1);
      check("R2 ready low", {63'h0, in_ready}, 64'h0);
      check("R2 hold word", {32'h0, out_word}, {32'h0, ref_word(acc_a, 1'b0, 1'b1, 1'b0)});
      check("R2 hold prod", {24'h0, out_prod}, {24'h0, ref_prod(32'h0100_0000, 32'h3, 1'b1)});
    end
    check("R1 ready rule under stall", {63'h0, in_ready}, 64'h0);
    out_ready = 1'b1;
    @(negedge clk);
    check("R1 beat B after release", {32'h0, out_word}, {32'h0, ref_word(acc_b, 1'b0, 1'b1, 1'b0)});
    check("R1 beat B prod", {24'h0, out_prod}, {24'h0, ref_prod(32'h0200_0000, 32'h9, 1'b1)});
    in_valid = 1'b0;
    @(negedge clk);
    check("R1 drained", {63'h0, out_valid}, 64'h0);
    check("R1 ready when empty", {63'h0, in_ready}, 64'h1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule